// File: doc/BRIEF.md
# Endian Address Rewriting Unit

This unit sits between a load/store pipeline and a 64-bit data bus. It presents memory as little-endian to software without touching the data path. When little-endian operation is active, it rewrites the low three bits of the effective address. The data lanes stay fixed in big-endian order, and the rewritten address picks the lane a byte, halfword or word lands in. The XOR key depends on the operand width, so a value of any size reads back in the order software expects.

The unit holds the active endianness bit and a second bit that gives the endianness for exception handlers. On exception entry, the handler bit becomes active and the interrupted mode is saved. On exception return, the saved mode is restored.

Page-table walk accesses always see plain big-endian addresses. 128-bit vector accesses are handled like doubleword accesses. Each access also produces one byte-lane enable per lane of the doubleword. An access that would spill past the doubleword raises an alignment flag and is passed through unchanged.

Top module: `endian_addr_xform`

## Requirements
- R1: In little-endian mode, a data-class access (class code 0 or 3) has address bits [2:0] XORed with a key that depends on the size code. The keys are: size 0 (byte) key 7, size 1 (halfword) key 6, size 2 (word) key 4, size 3 (doubleword) key 0. Bits above bit 2 are never altered.
- R2: In big-endian mode (active bit 0), the output address equals the input address for every class and size.
- R3: Pulsing `mode_wr_en` loads `mode_wr_val` into the active bit. The new value governs accesses from the cycle after the clock edge, not before.
- R4: On `exc_enter`, the active bit takes the value the handler bit held before that edge, and the previous active bit is saved.
- R5: On `exc_return` (without `exc_enter`), the active bit is restored from the saved copy.
- R6: In one cycle, `exc_enter` wins over `exc_return`, and both win over a mode write.
- R7: After reset, the active, handler and saved bits are all 0 (big-endian).
- R8: Page-table walk accesses (class code 1) are never rewritten, whatever the active bit.
- R9: Vector accesses (class code 2) use key 0 and enable all eight lanes, whatever the size code.
- R10: `lane_en[i]` enables byte lane i. Lane 0 is the most significant byte, at doubleword offset 0. The enabled lanes are offsets o to o+n-1, where o is the rewritten offset and n is the byte count (1, 2, 4 or 8).
- R11: `align_err` is 1 when the original offset plus n exceeds 8, or when the rewritten offset plus n exceeds 8. When it is set, the address passes through unchanged and no lane is enabled.
- R12: A doubleword at a given address yields the same output address and the same lanes in both modes. A value stored in one mode therefore reads back unchanged in the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_wr_en | input | 1 | Write strobe for the active endianness bit |
| mode_wr_val | input | 1 | Value written to the active bit (1 = little-endian) |
| hdl_wr_en | input | 1 | Write strobe for the handler endianness bit |
| hdl_wr_val | input | 1 | Value written to the handler bit |
| exc_enter | input | 1 | Exception entry pulse |
| exc_return | input | 1 | Exception return pulse |
| ea | input | AW | Effective address of the access |
| op_size | input | 2 | Size code: 0 byte, 1 halfword, 2 word, 3 doubleword |
| acc_class | input | 2 | Class: 0 data, 1 table walk, 2 vector, 3 data |
| pa | output | AW | Rewritten address |
| lane_en | output | 8 | Byte-lane enables, bit i = lane i |
| align_err | output | 1 | Access spills past the doubleword |
| cur_le | output | 1 | Active endianness bit |

## Verification
The embedded assertions watch several rules on every clock cycle:

- the mode-bit transitions on writes, exception entry and exception return;
- the pass-through of the address in big-endian mode and for table walks;
- the silencing of an access that raises an alignment error;
- the agreement between the number of enabled lanes and the operand width.

Some behaviour only the bench scenarios can show. The bench sweeps every offset, size and class in both modes and compares each result with an arithmetic model. That sweep shows the exact per-size XOR keys, the position of each lane, and the double-sided alignment rule. Directed sequences show the one-cycle delay of a mode write, the same-cycle priority ordering, and the reset values. They also show the doubleword read-back across a mode change.

// File: rtl/endian_xf_pkg.sv
// Shared encodings for the endian address rewriting unit.
package endian_xf_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } op_size_e;

    typedef enum logic [1:0] {
        AC_DATA = 2'd0,
        AC_WALK = 2'd1,
        AC_VEC  = 2'd2,
        AC_DATA2 = 2'd3
    } acc_class_e;
endpackage

// File: rtl/endian_mode_ctl.sv
// Holds the active, handler and saved endianness bits.
// Assumes exception entry and return arrive as single-cycle pulses.
// Nesting is one level deep; the saved copy is overwritten on every entry.
module endian_mode_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_wr_en,
    input  logic mode_wr_val,
    input  logic hdl_wr_en,
    input  logic hdl_wr_val,
    input  logic exc_enter,
    input  logic exc_return,
    output logic cur_le,
    output logic hdl_le
);
    logic saved_le;

    // Update the mode bits: entry beats return, and both beat a mode write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_le   <= 1'b0;
            hdl_le   <= 1'b0;
            saved_le <= 1'b0;
        end else begin
            if (hdl_wr_en) hdl_le <= hdl_wr_val;
            if (exc_enter) begin
                saved_le <= cur_le;
                cur_le   <= hdl_le;
            end else if (exc_return) begin
                cur_le <= saved_le;
            end else if (mode_wr_en) begin
                cur_le <= mode_wr_val;
            end
        end
    end

    // R3 / R6: a plain mode write lands on the next cycle
    a_r3_mode_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr_en && !exc_enter && !exc_return) |=> (cur_le == $past(mode_wr_val)));

    // R4 / R6: entry takes the handler bit and saves the interrupted mode
    a_r4_enter: assert property (@(posedge clk) disable iff (!rst_n)
        exc_enter |=> (cur_le == $past(hdl_le)) && (saved_le == $past(cur_le)));

    // R5: return restores the saved mode
    a_r5_return: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_return && !exc_enter) |=> (cur_le == $past(saved_le)));
endmodule

// File: rtl/endian_size_dec.sv
// Turns size code, access class and active mode into a byte count and an XOR key.
// Assumes a lane count that is a power of two of at least 8.
module endian_size_dec #(
    parameter int LANES = 8,
    localparam int OFFW = $clog2(LANES),
    localparam int NBW  = OFFW + 1
) (
    input  logic [1:0]      op_size,
    input  logic [1:0]      acc_class,
    input  logic            cur_le,
    output logic [NBW-1:0]  nbytes,
    output logic [OFFW-1:0] xor_key
);
    import endian_xf_pkg::*;

    logic           rewrite;
    logic [NBW-1:0] gap;

    // Byte count: vectors act as full doublewords, others decode the size code.
    always_comb begin
        if (acc_class == AC_VEC) nbytes = NBW'(LANES);
        else                     nbytes = NBW'(1) << op_size;
    end

    // Key is lanes minus bytes; table walks and big-endian mode use zero.
    always_comb begin
        rewrite = cur_le && (acc_class != AC_WALK);
        gap     = NBW'(LANES) - nbytes;
        xor_key = rewrite ? gap[OFFW-1:0] : '0;
    end
endmodule

// File: rtl/endian_lane_gen.sv
// Builds byte-lane enables and the alignment flag.
// It looks at both the original and the rewritten doubleword offset.
// Lane 0 is the most significant byte of the bus.
module endian_lane_gen #(
    parameter int LANES = 8,
    localparam int OFFW = $clog2(LANES),
    localparam int NBW  = OFFW + 1,
    localparam int EW   = OFFW + 2
) (
    input  logic [OFFW-1:0]  off_raw,
    input  logic [OFFW-1:0]  off_adj,
    input  logic [NBW-1:0]   nbytes,
    output logic             align_err,
    output logic [LANES-1:0] lane_en
);
    logic [EW-1:0] end_raw;
    logic [EW-1:0] end_adj;

    // Flag any access whose span leaves the doubleword before or after rewriting.
    always_comb begin
        end_raw   = EW'(off_raw) + EW'(nbytes);
        end_adj   = EW'(off_adj) + EW'(nbytes);
        align_err = (end_raw > EW'(LANES)) || (end_adj > EW'(LANES));
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // Lane i is enabled when it falls inside the rewritten span.
        always_comb begin
            lane_en[i] = !align_err && (EW'(i) >= EW'(off_adj)) && (EW'(i) < end_adj);
        end
    end
endmodule

// File: rtl/endian_addr_xform.sv
// Top of the endian address rewriting unit.
// Produces the bus address, the lane enables and the alignment flag for each access.
// The access inputs are combinational; only the mode bits are registered.
module endian_addr_xform #(
    parameter int AW    = 32,
    parameter int LANES = 8,
    localparam int OFFW = $clog2(LANES),
    localparam int NBW  = OFFW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_wr_en,
    input  logic             mode_wr_val,
    input  logic             hdl_wr_en,
    input  logic             hdl_wr_val,
    input  logic             exc_enter,
    input  logic             exc_return,
    input  logic [AW-1:0]    ea,
    input  logic [1:0]       op_size,
    input  logic [1:0]       acc_class,
    output logic [AW-1:0]    pa,
    output logic [LANES-1:0] lane_en,
    output logic             align_err,
    output logic             cur_le
);
    import endian_xf_pkg::*;

    logic            hdl_le;
    logic [NBW-1:0]  nbytes;
    logic [OFFW-1:0] xor_key;
    logic [OFFW-1:0] off_adj;

    endian_mode_ctl u_mode (
        .clk(clk), .rst_n(rst_n),
        .mode_wr_en(mode_wr_en), .mode_wr_val(mode_wr_val),
        .hdl_wr_en(hdl_wr_en), .hdl_wr_val(hdl_wr_val),
        .exc_enter(exc_enter), .exc_return(exc_return),
        .cur_le(cur_le), .hdl_le(hdl_le)
    );

    endian_size_dec #(.LANES(LANES)) u_dec (
        .op_size(op_size), .acc_class(acc_class), .cur_le(cur_le),
        .nbytes(nbytes), .xor_key(xor_key)
    );

    // Rewritten doubleword offset.
    always_comb off_adj = ea[OFFW-1:0] ^ xor_key;

    endian_lane_gen #(.LANES(LANES)) u_lanes (
        .off_raw(ea[OFFW-1:0]), .off_adj(off_adj), .nbytes(nbytes),
        .align_err(align_err), .lane_en(lane_en)
    );

    // Output address: the rewritten offset, or the raw address on an alignment error.
    always_comb pa = align_err ? ea : {ea[AW-1:OFFW], off_adj};

    // R2: big-endian mode leaves the address alone
    a_r2_be_flat: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_le |-> (pa == ea));

    // R8: table walks are never rewritten
    a_r8_walk_flat: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_class == AC_WALK) |-> (pa == ea));

    // R1: upper address bits are always preserved
    a_r1_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        pa[AW-1:OFFW] == ea[AW-1:OFFW]);

    // R11: an alignment error silences the lanes and passes the address through
    a_r11_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |-> (lane_en == '0) && (pa == ea));

    // R10: a legal access enables exactly as many lanes as it has bytes
    a_r10_lane_count: assert property (@(posedge clk) disable iff (!rst_n)
        !align_err |-> ($countones(lane_en) == int'(nbytes)));
endmodule

// File: tb/endian_addr_xform_bench.sv
module endian_addr_xform_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_wr_en = 1'b0, mode_wr_val = 1'b0;
    logic        hdl_wr_en = 1'b0, hdl_wr_val = 1'b0;
    logic        exc_enter = 1'b0, exc_return = 1'b0;
    logic [31:0] ea = '0;
    logic [1:0]  op_size = '0, acc_class = '0;
    logic [31:0] pa;
    logic [7:0]  lane_en;
    logic        align_err, cur_le;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    endian_addr_xform u_endian_addr_xform (
        .clk(clk), .rst_n(rst_n),
        .mode_wr_en(mode_wr_en), .mode_wr_val(mode_wr_val),
        .hdl_wr_en(hdl_wr_en), .hdl_wr_val(hdl_wr_val),
        .exc_enter(exc_enter), .exc_return(exc_return),
        .ea(ea), .op_size(op_size), .acc_class(acc_class),
        .pa(pa), .lane_en(lane_en), .align_err(align_err), .cur_le(cur_le)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive one access in the current mode and compare it with the arithmetic model.
    task automatic probe(input bit le, input logic [1:0] cls, input logic [1:0] sz, input logic [2:0] off);
        int nb, key, adj;
        bit rew, err;
        logic [31:0] epa;
        logic [7:0]  elane;
        string tag;
        ea        = {$urandom() % 32'h1000_0000, 1'b0, off} ^ 32'h0;
        ea[2:0]   = off;
        op_size   = sz;
        acc_class = cls;
        #1;
        nb  = (cls == 2'd2) ? 8 : (1 << sz);
        rew = le && (cls != 2'd1);
        key = rew ? 8 - nb : 0;
        adj = int'(off) ^ key;
        err = (int'(off) + nb > 8) || (adj + nb > 8);
        epa = err ? ea : {ea[31:3], 3'(adj)};
        elane = '0;
        for (int i = 0; i < 8; i++)
            if (!err && i >= adj && i < adj + nb) elane[i] = 1'b1;
        if (err)             tag = "R11";
        else if (cls == 2'd1) tag = "R8";
        else if (cls == 2'd2) tag = "R9";
        else if (!le)         tag = "R2";
        else                  tag = "R1";
        check({tag, " addr"}, 64'(pa), 64'(epa));
        check("R10 lanes", 64'(lane_en), 64'(elane));
        check("R11 align", 64'(align_err), 64'(err));
    endtask

    task automatic sweep(input bit le);
        for (int c = 0; c < 4; c++)
            for (int s = 0; s < 4; s++)
                for (int o = 0; o < 8; o++)
                    probe(le, 2'(c), 2'(s), 3'(o));
    endtask

    // Apply control pulses for exactly one clock edge.
    task automatic pulse(input bit mw, input bit mv, input bit en, input bit rt);
        @(negedge clk);
        mode_wr_en = mw; mode_wr_val = mv; exc_enter = en; exc_return = rt;
        @(negedge clk);
        mode_wr_en = 1'b0; exc_enter = 1'b0; exc_return = 1'b0;
        #1;
    endtask

    task automatic set_hdl(input bit v);
        @(negedge clk);
        hdl_wr_en = 1'b1; hdl_wr_val = v;
        @(negedge clk);
        hdl_wr_en = 1'b0;
    endtask

    initial begin
        logic [31:0] pa_be;
        logic [7:0]  ln_be;
        repeat (3) @(negedge clk);
        #1;
        // R7: reset state is big-endian
        check("R7 reset mode", 64'(cur_le), 64'd0);
        ea = 32'h0000_1235; op_size = 2'd0; acc_class = 2'd0; #1;
        check("R7 reset addr", 64'(pa), 64'h1235);
        @(negedge clk); rst_n = 1'b1;
        // R7: the handler bit is also 0 after reset, so entry keeps big-endian
        pulse(0, 0, 1, 0);
        check("R7 handler reset", 64'(cur_le), 64'd0);
        pulse(0, 0, 0, 1);
        sweep(1'b0);

        // R12: doubleword result in big-endian mode
        ea = 32'hABCD_0128; op_size = 2'd3; acc_class = 2'd0; #1;
        pa_be = pa; ln_be = lane_en;

        // R3: a write takes effect only after the edge
        @(negedge clk);
        mode_wr_en = 1'b1; mode_wr_val = 1'b1; #1;
        check("R3 before edge", 64'(cur_le), 64'd0);
        @(negedge clk);
        mode_wr_en = 1'b0; #1;
        check("R3 after edge", 64'(cur_le), 64'd1);

        ea = 32'hABCD_0128; op_size = 2'd3; acc_class = 2'd0; #1;
        check("R12 dword addr", 64'(pa), 64'(pa_be));
        check("R12 dword lanes", 64'(lane_en), 64'(ln_be));

        sweep(1'b1);

        // R4 / R5: the handler runs big-endian, then little-endian comes back
        set_hdl(1'b0);
        pulse(0, 0, 1, 0);
        check("R4 enter", 64'(cur_le), 64'd0);
        pulse(0, 0, 0, 1);
        check("R5 return", 64'(cur_le), 64'd1);

        // R6: entry beats a mode write in the same cycle
        pulse(1, 1, 1, 0);
        check("R6 enter over write", 64'(cur_le), 64'd0);
        // R6: return beats a mode write
        pulse(1, 0, 0, 1);
        check("R6 return over write", 64'(cur_le), 64'd1);
        // R6: entry beats return
        pulse(0, 0, 1, 1);
        check("R6 enter over return", 64'(cur_le), 64'd0);
        pulse(0, 0, 0, 1);

        // R4: a little-endian handler entered from big-endian mode
        pulse(1, 0, 0, 0);
        check("R3 clear", 64'(cur_le), 64'd0);
        set_hdl(1'b1);
        pulse(0, 0, 1, 0);
        check("R4 enter le", 64'(cur_le), 64'd1);
        ea = 32'h0000_0040; op_size = 2'd0; acc_class = 2'd0; #1;
        check("R1 handler byte", 64'(pa), 64'h47);
        pulse(0, 0, 0, 1);
        check("R5 return be", 64'(cur_le), 64'd0);

        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule